// File: doc/BRIEF.md
# BCD Real-Time Clock with Time Snapshot

This block keeps time of day in packed BCD inside a small byte-wide register RAM. A 32-bit bus reaches the RAM through a window of word-spaced byte registers. A free-running base tick is divided by a programmable prescaler, and each prescaler wrap advances the hundredths byte. Carries then ripple through seconds, minutes and hours into a day counter.

Software reads the time directly. It can also arm a snapshot that copies the seconds-to-month group into a shadow area in a single clock edge, so the copy stays coherent while the live fields keep counting. Month, year and day-of-week are plain storage that only bus writes change.

Top module: `bcd_rtc`

## Requirements
- R1: A bus access hits the RAM only when its byte address is word aligned and lies in WIN_BASE .. WIN_BASE+4*NREG-4 (default 0xE00..0xE7C). The byte index is (address-WIN_BASE)/4. Reads outside the window, or at a misaligned address, return 0, and writes there change nothing.
- R2: A write stores bits 7:0 of the data word into the addressed byte. A read returns that byte with bits 31:8 zero.
- R3: Reset clears the prescaler phase and every RAM byte. The hundredths byte (index 5) advances once for every PRESCALE cycles with tick high (default 100), whether or not those cycles are consecutive. Without a tick or a write, no byte changes.
- R4: Hundredths count in packed BCD, 00 to 99. A low digit of 9 rolls to 0 and increments the high digit. The step from 99 goes to 00 and carries one into seconds.
- R5: Seconds (index 6) and minutes (index 7) count 00 to 59 in BCD. Each wraps from 59 to 00 and carries into the next field.
- R6: Hours (index 8) count 00 to 23 in BCD. The step from 23 goes to 00 and increments the day byte (index 9).
- R7: The day byte increments in BCD from 00 to 99 and wraps to 00, with no month-length check. Month (index 0x0A), year (0x0B) and day-of-week (0x0E) never change on a carry.
- R8: A write to index 4 with data bit 7 set, while bit 7 of index 0 is clear, copies indices 6..10 (seconds, minutes, hours, day, month) into indices 0x19..0x1D. The copied values are the ones held before that clock edge. Index 4 also stores the written byte.
- R9: A write to index 4 with data bit 7 clear, or any write to index 4 while bit 7 of index 0 is set, leaves indices 0x19..0x1D unchanged.
- R10: When a bus write to a time field lands in the same cycle as an advance of that field, the written value is stored. No carry passes from that field to the next one in that cycle. Lower fields still advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Base time tick, one count per cycle it is high |
| bus_en | input | 1 | Bus access valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wdata | input | DATA_W (32) | Write data; only bits 7:0 are stored |
| bus_rdata | output | DATA_W (32) | Read data, combinational, zero-extended byte |

## Verification
The bench builds two copies of the block. One keeps the default prescale of 100, so the exact divide count and its behaviour under gapped ticks can be observed. The other is built with PRESCALE set to 1, which selects the pass-through prescaler variant. That copy makes every tick a hundredths step, so a whole minute of hundredths and seconds can be swept exhaustively. Every minute, hour and day value is also driven across its carry boundary from a bus preset. Both copies use the default 32-byte window at 0xE00, which places the snapshot area and the gate bit in their reachable positions.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

   typedef logic [7:0] rtc_byte_t;

   // byte indices the behaviour depends on
   localparam int IX_GATE    = 0;    // bit 7 blocks the snapshot
   localparam int IX_ARM     = 4;    // writing bit 7 here fires the snapshot
   localparam int IX_TIME0   = 5;    // hundredths, then sec, min, hour, day
   localparam int N_TIME     = 5;
   localparam int IX_MONTH   = 10;
   localparam int IX_YEAR    = 11;
   localparam int IX_WEEKDAY = 14;
   localparam int IX_SNAPSRC = 6;    // seconds .. month
   localparam int IX_SNAP0   = 25;
   localparam int N_SNAP     = 5;

   // last legal value of each chained field before it wraps
   function automatic rtc_byte_t wrap_of(input int k);
      case (k)
         0:       wrap_of = 8'h99;
         1:       wrap_of = 8'h59;
         2:       wrap_of = 8'h59;
         3:       wrap_of = 8'h23;
         default: wrap_of = 8'h99;
      endcase
   endfunction

   function automatic logic bcd_at_wrap(input rtc_byte_t v, input rtc_byte_t w);
      bcd_at_wrap = (v == w);
   endfunction

   function automatic rtc_byte_t bcd_next(input rtc_byte_t v, input rtc_byte_t w);
      if (v == w)
         bcd_next = 8'h00;
      else if (v[3:0] >= 4'd9)
         bcd_next = {v[7:4] + 4'd1, 4'h0};
      else
         bcd_next = v + 8'd1;
   endfunction

endpackage

// File: rtl/bcd_rtc_prescaler.sv
module bcd_rtc_prescaler #(
   parameter int PRESCALE = 100,
   parameter int PH_W     = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   output logic            step,
   output logic [PH_W-1:0] phase
);

   generate
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("bcd_rtc_prescaler: PRESCALE must be at least 1");
      end

      if (PRESCALE == 1) begin : g_passthru
         assign step  = tick;
         assign phase = '0;
      end else begin : g_divide
         localparam logic [PH_W-1:0] LAST = PH_W'(PRESCALE - 1);
         logic [PH_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (tick)
               cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end

         assign step  = tick && (cnt_q == LAST);
         assign phase = cnt_q;
      end
   endgenerate

endmodule

// File: rtl/bcd_rtc_decode.sv
module bcd_rtc_decode #(
   parameter int                ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] WIN_BASE = 12'hE00,
   parameter int                NREG     = 32,
   parameter int                IDX_W    = $clog2(NREG)
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);

   localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(NREG * 4);

   logic [ADDR_W-1:0] off;

   assign off = addr - WIN_BASE;
   assign hit = (addr >= WIN_BASE) && ({1'b0, off} < SPAN) && (off[1:0] == 2'b00);
   assign idx = off[IDX_W+1:2];

endmodule

// File: rtl/bcd_rtc_time_chain.sv
module bcd_rtc_time_chain
   import bcd_rtc_pkg::*;
#(
   parameter int NF = N_TIME
) (
   input  logic                 step,
   input  logic [NF-1:0][7:0]   cur,
   input  logic [NF-1:0]        hold,
   output logic [NF-1:0]        adv,
   output logic [NF-1:0][7:0]   nxt
);

   logic [NF-1:0] en;

   assign en[0] = step;

   generate
      for (genvar i = 0; i < NF; i++) begin : g_field
         localparam rtc_byte_t WRAP = wrap_of(i);

         assign nxt[i] = bcd_next(cur[i], WRAP);
         assign adv[i] = en[i] && !hold[i];

         if (i < NF - 1) begin : g_carry
            assign en[i+1] = adv[i] && bcd_at_wrap(cur[i], WRAP);
         end
      end
   endgenerate

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
   import bcd_rtc_pkg::*;
#(
   parameter int                ADDR_W       = 12,
   parameter int                DATA_W       = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE     = 12'hE00,
   parameter int                NREG         = 32,
   parameter int                PRESCALE     = 100,
   parameter bit                CLEAR_ON_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);

   localparam int IDX_W = $clog2(NREG);
   localparam int PH_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("bcd_rtc: DATA_W must hold a byte");
      end
      if (NREG < IX_SNAP0 + N_SNAP || (1 << IDX_W) != NREG) begin : g_bad_depth
         $error("bcd_rtc: NREG must be a power of two covering the snapshot area");
      end
      if (WIN_BASE[1:0] != 2'b00) begin : g_bad_base
         $error("bcd_rtc: WIN_BASE must be word aligned");
      end
      if (int'(WIN_BASE) + 4 * NREG > (1 << ADDR_W)) begin : g_bad_window
         $error("bcd_rtc: window does not fit the address space");
      end
   endgenerate

   logic [NREG-1:0][7:0] ram_q, ram_d;
   logic                 hit;
   logic [IDX_W-1:0]     acc_idx;
   logic                 wr_en;
   logic                 step;
   logic [PH_W-1:0]      pre_phase;
   logic                 snap_fire;
   logic [N_TIME-1:0]    hold, adv;
   logic [N_TIME-1:0][7:0] cur_t, nxt_t;
   logic                 unused_wdata_hi;

   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:8];

   bcd_rtc_decode #(
      .ADDR_W   (ADDR_W),
      .WIN_BASE (WIN_BASE),
      .NREG     (NREG),
      .IDX_W    (IDX_W)
   ) u_decode (
      .addr (bus_addr),
      .hit  (hit),
      .idx  (acc_idx)
   );

   bcd_rtc_prescaler #(
      .PRESCALE (PRESCALE),
      .PH_W     (PH_W)
   ) u_prescale (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .step  (step),
      .phase (pre_phase)
   );

   assign wr_en = bus_en && bus_we && hit;

   generate
      for (genvar k = 0; k < N_TIME; k++) begin : g_time_io
         assign cur_t[k] = ram_q[IX_TIME0 + k];
         assign hold[k]  = wr_en && (acc_idx == IDX_W'(IX_TIME0 + k));
      end
   endgenerate

   bcd_rtc_time_chain #(
      .NF (N_TIME)
   ) u_chain (
      .step (step),
      .cur  (cur_t),
      .hold (hold),
      .adv  (adv),
      .nxt  (nxt_t)
   );

   assign snap_fire = wr_en && (acc_idx == IDX_W'(IX_ARM)) &&
                      bus_wdata[7] && !ram_q[IX_GATE][7];

   always_comb begin
      ram_d = ram_q;
      for (int k = 0; k < N_SNAP; k++) begin
         if (snap_fire)
            ram_d[IX_SNAP0 + k] = ram_q[IX_SNAPSRC + k];
      end
      for (int k = 0; k < N_TIME; k++) begin
         if (adv[k])
            ram_d[IX_TIME0 + k] = nxt_t[k];
      end
      if (wr_en)
         ram_d[acc_idx] = bus_wdata[7:0];
   end

   generate
      if (CLEAR_ON_RST) begin : g_ram_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ram_q <= '0;
            else
               ram_q <= ram_d;
         end
      end else begin : g_ram_keep
         always_ff @(posedge clk) begin
            ram_q <= ram_d;
         end
      end
   endgenerate

   assign bus_rdata = (bus_en && hit) ? DATA_W'(ram_q[acc_idx]) : '0;

endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk
   import bcd_rtc_pkg::*;
#(
   parameter int NREG     = 32,
   parameter int IDX_W    = 5,
   parameter int PRESCALE = 100,
   parameter int PH_W     = 7
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 step,
   input logic                 wr_en,
   input logic [IDX_W-1:0]     wr_idx,
   input logic [7:0]           wr_byte,
   input logic [NREG-1:0][7:0] ram_q,
   input logic [PH_W-1:0]      phase
);

   a_r3_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(phase) < PRESCALE);

   a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !wr_en) |=> $stable(ram_q));

   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ram_q[$past(wr_idx)] == $past(wr_byte));

   a_r7_calendar_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(ram_q[IX_MONTH]) && $stable(ram_q[IX_YEAR]) &&
                  $stable(ram_q[IX_WEEKDAY])));

   a_r8_snap_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(IX_ARM) && wr_byte[7] && !ram_q[IX_GATE][7])
      |=> (ram_q[IX_SNAP0] == $past(ram_q[IX_SNAPSRC]) &&
           ram_q[IX_SNAP0+4] == $past(ram_q[IX_SNAPSRC+4])));

   a_r9_snap_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(IX_ARM) && (ram_q[IX_GATE][7] || !wr_byte[7]))
      |=> $stable(ram_q[IX_SNAP0+N_SNAP-1:IX_SNAP0]));

   a_r10_write_blocks_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(IX_TIME0+1))
      |=> $stable(ram_q[IX_TIME0+4:IX_TIME0+2]));

endmodule

bind bcd_rtc bcd_rtc_chk #(
   .NREG     (NREG),
   .IDX_W    (IDX_W),
   .PRESCALE (PRESCALE),
   .PH_W     (PH_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .step    (step),
   .wr_en   (wr_en),
   .wr_idx  (acc_idx),
   .wr_byte (bus_wdata[7:0]),
   .ram_q   (ram_q),
   .phase   (pre_phase)
);

// File: tb/bcd_rtc_tb.sv
module bcd_rtc_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_en, bus_we;
   logic [11:0] bus_addr;
   logic [31:0] bus_wdata;
   logic        tick_s, tick_f;
   logic [31:0] rdata_s, rdata_f;
   int          n_chk = 0;
   int          n_err = 0;

   always #2 clk = ~clk;

   bcd_rtc #(.PRESCALE(100)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick_s), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_s));

   bcd_rtc #(.PRESCALE(1)) dut_fast_i (
      .clk(clk), .rst_n(rst_n), .tick(tick_f), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_f));

   function automatic logic [7:0] bcd(input int n);
      return 8'(((n / 10) << 4) | (n % 10));
   endfunction

   function automatic logic [11:0] ax(input int idx);
      return 12'(12'hE00 + idx * 4);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic wr_a(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic wr(input int idx, input logic [7:0] d);
      wr_a(ax(idx), {24'hA5C3E1, d});
   endtask

   task automatic rd_a(input logic [11:0] a, input bit fast, output logic [31:0] v);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 v = fast ? rdata_f : rdata_s;
      bus_en = 1'b0;
   endtask

   task automatic chk_idx(input string tag, input bit fast, input int idx, input logic [7:0] e);
      logic [31:0] v;
      rd_a(ax(idx), fast, v);
      check(tag, v, {24'h0, e});
   endtask

   task automatic pulse_fast();
      @(negedge clk); tick_f = 1'b1;
      @(negedge clk); tick_f = 1'b0;
   endtask

   task automatic preset(input logic [7:0] h, s, m, hr, d);
      wr(5, h); wr(6, s); wr(7, m); wr(8, hr); wr(9, d);
   endtask

   initial begin : watchdog
      #(200000 * 4);
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
      tick_s = 1'b0; tick_f = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R3 reset state
      for (int i = 0; i < 32; i++) chk_idx("R3 reset clears byte", 1'b0, i, 8'h00);

      // R1 R2 every index written and read back zero-extended
      for (int i = 0; i < 32; i++) wr(i, 8'(i * 5 + 3));
      for (int i = 0; i < 32; i++) chk_idx("R2 low byte stored", 1'b0, i, 8'(i * 5 + 3));

      // R1 outside window and misaligned
      wr_a(12'hE80, 32'h000000AA);
      rd_a(12'hE80, 1'b0, v);  check("R1 above window reads 0", v, 32'h0);
      wr_a(12'hDFC, 32'h000000BB);
      rd_a(12'hDFC, 1'b0, v);  check("R1 below window reads 0", v, 32'h0);
      wr_a(12'hE02, 32'h00000055);
      rd_a(12'hE01, 1'b0, v);  check("R1 misaligned read 0", v, 32'h0);
      chk_idx("R1 misaligned write ignored", 1'b0, 0, 8'h03);
      chk_idx("R1 top index unchanged", 1'b0, 31, 8'h9E);
      for (int i = 0; i < 32; i++) wr(i, 8'h00);

      // R3 prescale by 100, consecutive then gapped
      @(negedge clk); tick_s = 1'b1;
      repeat (99) @(negedge clk);
      tick_s = 1'b0;
      chk_idx("R3 99 ticks no step", 1'b0, 5, 8'h00);
      @(negedge clk); tick_s = 1'b1;
      @(negedge clk); tick_s = 1'b0;
      chk_idx("R3 100th tick steps", 1'b0, 5, 8'h01);
      for (int i = 0; i < 100; i++) begin
         @(negedge clk); tick_s = 1'b1;
         @(negedge clk); tick_s = 1'b0;
         @(negedge clk);
      end
      chk_idx("R3 gapped ticks step once", 1'b0, 5, 8'h02);
      chk_idx("R3 seconds untouched", 1'b0, 6, 8'h00);

      // R4 R5 exhaustive minute of hundredths on the pass-through copy
      preset(8'h00, 8'h00, 8'h58, 8'h10, 8'h00);
      for (int k = 1; k <= 6000; k++) begin
         pulse_fast();
         chk_idx("R4 hundredths sweep", 1'b1, 5, bcd(k % 100));
         chk_idx("R5 seconds sweep", 1'b1, 6, bcd((k / 100) % 60));
      end
      chk_idx("R5 seconds carry into minutes", 1'b1, 7, 8'h59);

      // R5 every minute value
      for (int m = 0; m < 60; m++) begin
         preset(8'h99, 8'h59, bcd(m), 8'h05, 8'h00);
         pulse_fast();
         chk_idx("R5 minute step", 1'b1, 7, bcd((m + 1) % 60));
         chk_idx("R5 minute carry to hour", 1'b1, 8, (m == 59) ? 8'h06 : 8'h05);
      end

      // R6 every hour value
      for (int h = 0; h < 24; h++) begin
         preset(8'h99, 8'h59, 8'h59, bcd(h), 8'h29);
         pulse_fast();
         chk_idx("R6 hour step", 1'b1, 8, bcd((h + 1) % 24));
         chk_idx("R6 hour carry to day", 1'b1, 9, (h == 23) ? 8'h30 : 8'h29);
         chk_idx("R6 lower fields cleared", 1'b1, 5, 8'h00);
      end

      // R7 every day value, calendar bytes untouched
      wr(10, 8'h12); wr(11, 8'h99); wr(14, 8'h07);
      for (int d = 0; d < 100; d++) begin
         preset(8'h99, 8'h59, 8'h59, 8'h23, bcd(d));
         pulse_fast();
         chk_idx("R7 day step", 1'b1, 9, bcd((d + 1) % 100));
      end
      chk_idx("R7 month fixed", 1'b1, 10, 8'h12);
      chk_idx("R7 year fixed", 1'b1, 11, 8'h99);
      chk_idx("R7 weekday fixed", 1'b1, 14, 8'h07);

      // R8 snapshot
      wr(0, 8'h00);
      wr(6, 8'h42); wr(7, 8'h17); wr(8, 8'h21); wr(9, 8'h31); wr(10, 8'h11);
      wr(4, 8'h80);
      chk_idx("R8 snap seconds", 1'b0, 25, 8'h42);
      chk_idx("R8 snap minutes", 1'b0, 26, 8'h17);
      chk_idx("R8 snap hours", 1'b0, 27, 8'h21);
      chk_idx("R8 snap day", 1'b0, 28, 8'h31);
      chk_idx("R8 snap month", 1'b0, 29, 8'h11);
      chk_idx("R8 arm byte stored", 1'b0, 4, 8'h80);

      // R9 gate bit and clear data bit block the copy
      wr(6, 8'h05);
      wr(0, 8'h80); wr(4, 8'h80);
      chk_idx("R9 gate blocks snapshot", 1'b0, 25, 8'h42);
      wr(0, 8'h00); wr(4, 8'h7F);
      chk_idx("R9 bit7 clear no snapshot", 1'b0, 25, 8'h42);
      wr(4, 8'h80);
      chk_idx("R8 snapshot after ungating", 1'b0, 25, 8'h05);

      // R10 write beats a same-cycle advance
      preset(8'h99, 8'h30, 8'h10, 8'h02, 8'h00);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = ax(6); bus_wdata = 32'h10; tick_f = 1'b1;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0; tick_f = 1'b0;
      chk_idx("R10 written seconds kept", 1'b1, 6, 8'h10);
      chk_idx("R10 lower field advanced", 1'b1, 5, 8'h00);
      preset(8'h99, 8'h59, 8'h10, 8'h02, 8'h00);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = ax(6); bus_wdata = 32'h59; tick_f = 1'b1;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0; tick_f = 1'b0;
      chk_idx("R10 seconds held at write", 1'b1, 6, 8'h59);
      chk_idx("R10 no carry to minutes", 1'b1, 7, 8'h10);
      preset(8'h99, 8'h20, 8'h10, 8'h02, 8'h00);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = ax(5); bus_wdata = 32'h99; tick_f = 1'b1;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0; tick_f = 1'b0;
      chk_idx("R10 hundredths write wins", 1'b1, 5, 8'h99);
      chk_idx("R10 seconds not advanced", 1'b1, 6, 8'h20);

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule